// File: doc/BRIEF.md
# Partitioned Virtual-FIFO Transmit Buffer

This block is a write-side staging store for a packet transmit path. One shared memory is divided at run time into 1, 2, 4 or 8 equal regions. Each region behaves as an independent first-in first-out queue. A producer writes through a plain FIFO-style port. Each write carries a 3-bit partition select, a write strobe, a data word and per-entry sideband: start-of-packet, end-of-packet, an 8-bit byte-enable field and a 16-bit port tag. The word and its sideband are stored together in the partition that the select names.

The port continuously reports the fill level of the partition that the select currently names, along with a full flag. The full flag trips either at three-quarters of the partition share or at the whole share, as a configuration bit chooses. Writes into a full partition are dropped and flagged by an overflow pulse. A drain port pops the oldest entry of a chosen partition and returns it with its sideband. Changing the partition count empties every partition, and so does the counter-clear input.

Top module: `vfifo_tx_buffer`

## Requirements
- R1: Entries drained from a partition come out in the order they were written to it, and each carries the data, start-of-packet, end-of-packet, byte enables and port tag it was written with. Writes to one partition never appear in another.
- R2: `fillLevel` shows the entry count of the partition named by `wrAddr` combinationally, in the same cycle, whether or not `wrEn` is high. A write that is accepted raises it by one from the next cycle.
- R3: When `cfgFullAt3q` is 0, `fullFlag` is 1 exactly when the addressed partition holds its whole share. When `cfgFullAt3q` is 1, `fullFlag` is 1 exactly when that partition holds at least three quarters of its share.
- R4: `cfgPartLog2` values 0, 1, 2 and 3 give 1, 2, 4 and 8 partitions. Each partition holds 64 >> `cfgPartLog2` entries of the 64-entry memory.
- R5: A write to a partition that already holds its whole share is discarded. Its count and stored contents stay unchanged, and `overflowPulse` is 1 for exactly the following cycle.
- R6: A partition select at or above the configured partition count is ignored by both ports. A write there stores nothing and raises no overflow, a drain there returns nothing, and `fillLevel` and `fullFlag` read 0 while it is selected.
- R7: With `wrCountClr` high at a clock edge, every partition is empty after that edge. Any write or drain in that cycle is discarded.
- R8: A cycle in which `cfgPartLog2` differs from its value in the previous cycle empties every partition at its closing edge and discards that cycle's write and drain.
- R9: A drain request (`rdEn`) to an in-range, non-empty partition removes one entry. `rdValid` is 1 in the next cycle with the entry on the read outputs. A drain of an empty partition leaves `rdValid` at 0.
- R10: A write and a drain in the same cycle are each judged on the count before that edge. A write to a full partition is dropped even if a drain of that partition occurs in the same cycle. A drain of an empty partition returns nothing even if a write to that partition occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgPartLog2 | input | 2 | Log2 of the partition count |
| cfgFullAt3q | input | 1 | 1: full flag at three-quarters share; 0: at whole share |
| wrAddr | input | 3 | Partition select for writes and for the fill report |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Data word to store |
| wrByteEn | input | 8 | Byte enables stored with the word |
| wrSop | input | 1 | Start-of-packet marker stored with the word |
| wrEop | input | 1 | End-of-packet marker stored with the word |
| wrPortTag | input | 16 | Port identifier stored with the word |
| wrCountClr | input | 1 | Empties every partition |
| fillLevel | output | 7 | Entry count of the selected partition |
| fullFlag | output | 1 | Full indication for the selected partition |
| overflowPulse | output | 1 | One-cycle pulse after a discarded write into a full partition |
| rdAddr | input | 3 | Partition select for draining |
| rdEn | input | 1 | Drain request |
| rdValid | output | 1 | Read outputs hold a drained entry |
| rdData | output | 32 | Drained data word |
| rdByteEn | output | 8 | Drained byte enables |
| rdSop | output | 1 | Drained start-of-packet marker |
| rdEop | output | 1 | Drained end-of-packet marker |
| rdPortTag | output | 16 | Drained port identifier |

## Verification
The assertions assume that every input is a known value at each clock edge once reset is released. They also assume that `cfgPartLog2` stays within 0 to 3, since its 2-bit width allows no other value. The stimulus drives every input on the falling edge from a single task, and it moves between partition counts only while the other controls are idle or random. The cycle of a configuration change is therefore judged by the same emptying rule as the model. The bench keeps write traffic heavier than drain traffic so that partitions regularly reach their share under both threshold settings.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;
  localparam int unsigned VF_DATA_W    = 32;
  localparam int unsigned VF_DEPTH     = 64;
  localparam int unsigned VF_MAX_PARTS = 8;
  localparam int unsigned VF_TAG_W     = 16;
  localparam int unsigned VF_BE_W      = 8;

  localparam int unsigned VF_ADDR_W  = $clog2(VF_DEPTH);
  localparam int unsigned VF_CNT_W   = VF_ADDR_W + 1;
  localparam int unsigned VF_SEL_W   = $clog2(VF_MAX_PARTS);
  localparam int unsigned VF_LOG_W   = $clog2(VF_SEL_W + 1);
  localparam int unsigned VF_ENTRY_W = 2 + VF_BE_W + VF_TAG_W + VF_DATA_W;

  typedef struct packed {
    logic                 sop;
    logic                 eop;
    logic [VF_BE_W-1:0]   byteEn;
    logic [VF_TAG_W-1:0]  portTag;
    logic [VF_DATA_W-1:0] data;
  } vf_entry_t;

  typedef struct packed {
    logic                 memWr;
    logic [VF_ADDR_W-1:0] memWrAddr;
    logic                 memRd;
    logic [VF_ADDR_W-1:0] memRdAddr;
  } vf_strobe_t;
endpackage

// File: rtl/vfifo_ctrl.sv
module vfifo_ctrl
  import vfifo_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [VF_LOG_W-1:0] cfgPartLog2,
  input  logic                cfgFullAt3q,
  input  logic [VF_SEL_W-1:0] wrAddr,
  input  logic                wrEn,
  input  logic                wrCountClr,
  input  logic [VF_SEL_W-1:0] rdAddr,
  input  logic                rdEn,
  output logic [VF_CNT_W-1:0] fillLevel,
  output logic                fullFlag,
  output logic                overflowPulse,
  output vf_strobe_t          strobes
);
  localparam int AW   = VF_ADDR_W;
  localparam int CW   = VF_CNT_W;
  localparam int NP   = VF_MAX_PARTS;
  localparam int PC_W = VF_SEL_W + 1;

  logic [CW-1:0]       partDepth;
  logic [PC_W-1:0]     partCount;
  logic [CW+1:0]       thr3q;
  logic [VF_LOG_W-1:0] cfgQ;
  logic                clrAll;

  logic [CW-1:0] cnt   [NP];
  logic [AW-1:0] wrPtr [NP];
  logic [AW-1:0] rdPtr [NP];

  logic          wrInRange, rdInRange;
  logic [CW-1:0] selCnt, rdCnt;
  logic          wrAccept, wrOverflow, rdAccept;
  logic [AW-1:0] wrBase, rdBase;
  int            baseShift;

  function automatic logic [AW-1:0] ptrNext(input logic [AW-1:0] p, input logic [CW-1:0] d);
    return (({1'b0, p} + CW'(1)) == d) ? '0 : p + AW'(1);
  endfunction

  assign partDepth = CW'(VF_DEPTH) >> cfgPartLog2;
  assign partCount = PC_W'(1) << cfgPartLog2;
  assign thr3q     = ({2'b00, partDepth} * (CW+2)'(3)) >> 2;
  assign clrAll    = wrCountClr | (cfgPartLog2 != cfgQ);
  assign baseShift = AW - int'(cfgPartLog2);

  assign wrInRange = {1'b0, wrAddr} < partCount;
  assign rdInRange = {1'b0, rdAddr} < partCount;
  assign selCnt    = cnt[wrAddr];
  assign rdCnt     = cnt[rdAddr];

  assign fillLevel = wrInRange ? selCnt : '0;
  always_comb begin
    if (!wrInRange)      fullFlag = 1'b0;
    else if (cfgFullAt3q) fullFlag = {2'b00, selCnt} >= thr3q;
    else                 fullFlag = selCnt == partDepth;
  end

  assign wrAccept   = wrEn & wrInRange & ~clrAll & (selCnt != partDepth);
  assign wrOverflow = wrEn & wrInRange & ~clrAll & (selCnt == partDepth);
  assign rdAccept   = rdEn & rdInRange & ~clrAll & (rdCnt != '0);

  assign wrBase = AW'(wrAddr) << baseShift;
  assign rdBase = AW'(rdAddr) << baseShift;

  always_comb begin
    strobes.memWr     = wrAccept;
    strobes.memWrAddr = wrBase + wrPtr[wrAddr];
    strobes.memRd     = rdAccept;
    strobes.memRdAddr = rdBase + rdPtr[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ          <= '0;
      overflowPulse <= 1'b0;
    end else begin
      cfgQ          <= cfgPartLog2;
      overflowPulse <= wrOverflow;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_part
    logic wrHit, rdHit;
    assign wrHit = wrAccept && (wrAddr == VF_SEL_W'(g));
    assign rdHit = rdAccept && (rdAddr == VF_SEL_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[g]   <= '0;
        wrPtr[g] <= '0;
        rdPtr[g] <= '0;
      end else if (clrAll) begin
        cnt[g]   <= '0;
        wrPtr[g] <= '0;
        rdPtr[g] <= '0;
      end else begin
        if (wrHit) wrPtr[g] <= ptrNext(wrPtr[g], partDepth);
        if (rdHit) rdPtr[g] <= ptrNext(rdPtr[g], partDepth);
        case ({wrHit, rdHit})
          2'b10:   cnt[g] <= cnt[g] + CW'(1);
          2'b01:   cnt[g] <= cnt[g] - CW'(1);
          default: cnt[g] <= cnt[g];
        endcase
      end
    end

    // Count never exceeds the share of the current configuration.
    assert_share_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
      !clrAll |-> cnt[g] <= partDepth);
    // Clearing or reconfiguring leaves every partition empty.
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
      clrAll |=> cnt[g] == '0);
    // Out-of-range write alone changes no count.
    assert_ignored_select_R6: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !wrInRange && !rdEn && !clrAll) |=> $stable(cnt[g]));
  end

  // Overflow pulse follows a write seen at a whole-share fill level.
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |-> ($past(wrEn) && $past(fillLevel) == $past(partDepth)));
endmodule

// File: rtl/vfifo_datapath.sv
module vfifo_datapath
  import vfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  vf_strobe_t strobes,
  input  vf_entry_t  wrEntry,
  output logic       rdValid,
  output vf_entry_t  rdEntry
);
  vf_entry_t store [VF_DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.memWr) store[strobes.memWrAddr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (strobes.memRd) rdEntry <= store[strobes.memRdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= strobes.memRd;
  end

  // Valid output only after an accepted drain.
  assert_drain_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strobes.memRd));
endmodule

// File: rtl/vfifo_tx_buffer.sv
module vfifo_tx_buffer
  import vfifo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [VF_LOG_W-1:0]  cfgPartLog2,
  input  logic                 cfgFullAt3q,
  input  logic [VF_SEL_W-1:0]  wrAddr,
  input  logic                 wrEn,
  input  logic [VF_DATA_W-1:0] wrData,
  input  logic [VF_BE_W-1:0]   wrByteEn,
  input  logic                 wrSop,
  input  logic                 wrEop,
  input  logic [VF_TAG_W-1:0]  wrPortTag,
  input  logic                 wrCountClr,
  output logic [VF_CNT_W-1:0]  fillLevel,
  output logic                 fullFlag,
  output logic                 overflowPulse,
  input  logic [VF_SEL_W-1:0]  rdAddr,
  input  logic                 rdEn,
  output logic                 rdValid,
  output logic [VF_DATA_W-1:0] rdData,
  output logic [VF_BE_W-1:0]   rdByteEn,
  output logic                 rdSop,
  output logic                 rdEop,
  output logic [VF_TAG_W-1:0]  rdPortTag
);
  vf_strobe_t strobes;
  vf_entry_t  wrEntry, rdEntry;

  assign wrEntry = '{sop: wrSop, eop: wrEop, byteEn: wrByteEn, portTag: wrPortTag, data: wrData};

  vfifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgPartLog2(cfgPartLog2), .cfgFullAt3q(cfgFullAt3q),
    .wrAddr(wrAddr), .wrEn(wrEn), .wrCountClr(wrCountClr), .rdAddr(rdAddr), .rdEn(rdEn),
    .fillLevel(fillLevel), .fullFlag(fullFlag), .overflowPulse(overflowPulse), .strobes(strobes)
  );

  vfifo_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrEntry(wrEntry),
    .rdValid(rdValid), .rdEntry(rdEntry)
  );

  assign rdData    = rdEntry.data;
  assign rdByteEn  = rdEntry.byteEn;
  assign rdSop     = rdEntry.sop;
  assign rdEop     = rdEntry.eop;
  assign rdPortTag = rdEntry.portTag;
endmodule

// File: tb/vfifo_tx_buffer_bench.sv
module vfifo_tx_buffer_bench;
  import vfifo_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [1:0]  cfgPartLog2;
  logic        cfgFullAt3q;
  logic [2:0]  wrAddr, rdAddr;
  logic        wrEn, rdEn, wrCountClr, wrSop, wrEop;
  logic [31:0] wrData;
  logic [7:0]  wrByteEn;
  logic [15:0] wrPortTag;
  logic [6:0]  fillLevel;
  logic        fullFlag, overflowPulse, rdValid, rdSop, rdEop;
  logic [31:0] rdData;
  logic [7:0]  rdByteEn;
  logic [15:0] rdPortTag;

  vfifo_tx_buffer u_vfifo_tx_buffer (.*);

  typedef logic [VF_ENTRY_W-1:0] ent_t;
  ent_t mq [8][$];
  int   prevCfg;
  logic expRdValid, expOvf;
  ent_t expRd;
  int   checks = 0, failures = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One clock: check registered outputs, drive, check combinational outputs, advance model.
  task automatic cycle(input logic we, input logic [2:0] wa, input ent_t wd,
                       input logic re, input logic [2:0] ra, input logic clr);
    int pc, share, sz;
    bit clrNow, rdOk;
    ent_t popped;
    chk(rdValid === expRdValid, "R9", "rdValid", longint'(rdValid), longint'(expRdValid));
    if (expRdValid)
      chk({rdSop, rdEop, rdByteEn, rdPortTag, rdData} === expRd, "R1", "drained entry",
          longint'({rdSop, rdEop, rdByteEn, rdPortTag, rdData}), longint'(expRd));
    chk(overflowPulse === expOvf, "R5", "overflowPulse", longint'(overflowPulse), longint'(expOvf));
    wrEn = we; wrAddr = wa; rdEn = re; rdAddr = ra; wrCountClr = clr;
    {wrSop, wrEop, wrByteEn, wrPortTag, wrData} = wd;
    #1;
    pc = 1 << cfgPartLog2;
    share = 64 >> cfgPartLog2;
    sz = (int'(wa) < pc) ? mq[wa].size() : 0;
    chk(int'(fillLevel) == sz, (int'(wa) < pc) ? "R2" : "R6", "fillLevel", longint'(fillLevel), longint'(sz));
    chk(fullFlag === ((int'(wa) < pc) && (cfgFullAt3q ? (sz * 4 >= share * 3) : (sz == share))),
        (int'(wa) < pc) ? "R3" : "R6", "fullFlag", longint'(fullFlag),
        longint'((int'(wa) < pc) && (cfgFullAt3q ? (sz * 4 >= share * 3) : (sz == share))));
    clrNow = clr || (int'(cfgPartLog2) != prevCfg);   // R7, R8
    expOvf = 1'b0; rdOk = 1'b0; popped = '0;
    if (clrNow) begin
      for (int p = 0; p < 8; p++) mq[p].delete();
    end else begin
      rdOk = re && int'(ra) < pc && mq[ra].size() > 0;          // R10: judged on old count
      if (we && int'(wa) < pc) begin
        if (mq[wa].size() == share) expOvf = 1'b1;               // R5
      end
      if (rdOk) popped = mq[ra].pop_front();
      if (we && int'(wa) < pc && !expOvf) mq[wa].push_back(wd);
    end
    expRdValid = rdOk;
    expRd = popped;
    prevCfg = int'(cfgPartLog2);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic ent_t mk(input int n);
    return {n[0], n[1], 8'(n * 7), 16'(n * 13 + 1), 32'(n * 32'h01010101 + 5)};
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgPartLog2 = 2'd0; cfgFullAt3q = 1'b0;
    wrEn = 0; rdEn = 0; wrAddr = 0; rdAddr = 0; wrCountClr = 0;
    {wrSop, wrEop, wrByteEn, wrPortTag, wrData} = '0;
    prevCfg = 0; expRdValid = 0; expOvf = 0; expRd = '0;
    repeat (3) @(negedge clk);
    chk(fillLevel == 0 && !rdValid && !overflowPulse, "R2", "reset state",
        longint'({fillLevel, rdValid, overflowPulse}), 0);
    rstN = 1'b1;

    // R4: 8 partitions of 8 entries; R5: ninth write overflows
    cfgPartLog2 = 2'd3;
    cycle(0, 0, '0, 0, 0, 0);
    for (int i = 0; i < 9; i++) cycle(1, 3'd2, mk(i), 0, 0, 0);
    cycle(1, 3'd5, mk(100), 0, 0, 0);                  // R1 separate partition
    cycle(1, 3'd2, mk(50), 1, 3'd2, 0);                // R10 full + drain: write dropped
    for (int i = 0; i < 9; i++) cycle(0, 3'd2, '0, 1, 3'd2, 0);  // R9 drain to empty
    cycle(1, 3'd6, mk(7), 1, 3'd6, 0);                 // R10 empty + write: no drain
    cycle(0, 3'd5, '0, 1, 3'd5, 0);

    // R3: three-quarter threshold
    cfgFullAt3q = 1'b1;
    for (int i = 0; i < 9; i++) cycle(1, 3'd4, mk(200 + i), 0, 0, 0);
    // R7: counter clear
    cycle(1, 3'd4, mk(1), 1, 3'd4, 1);
    cycle(0, 3'd4, '0, 1, 3'd4, 0);

    // R8 and R6: 2 partitions of 32; select 5 out of range
    cfgPartLog2 = 2'd1;
    cycle(1, 3'd1, mk(3), 0, 0, 0);
    cycle(1, 3'd5, mk(9), 1, 3'd5, 0);
    for (int i = 0; i < 33; i++) cycle(1, 3'd1, mk(300 + i), 0, 0, 0);
    cfgFullAt3q = 1'b0;
    cycle(1, 3'd1, mk(4), 0, 0, 0);
    cycle(0, 3'd1, '0, 1, 3'd1, 0);
    cfgPartLog2 = 2'd0;                                // R8 reconfigure empties
    cycle(0, 3'd0, '0, 1, 3'd1, 0);
    cycle(0, 3'd0, '0, 1, 3'd0, 0);

    // mixed random traffic across configurations
    for (int n = 0; n < 6000; n++) begin
      if (n % 400 == 399) cfgPartLog2 = 2'($urandom_range(0, 3));
      if (n % 250 == 0) cfgFullAt3q = 1'($urandom_range(0, 1));
      cycle(($urandom_range(0, 9) < 7), 3'($urandom_range(0, 7)), ent_t'({$urandom, $urandom}),
            ($urandom_range(0, 9) < 4), 3'($urandom_range(0, 7)), ($urandom_range(0, 299) == 0));
    end
    for (int n = 0; n < 80; n++) cycle(0, 3'(n % 8), '0, 1, 3'(n % 8), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule